// File: doc/BRIEF.md
# Debug Pin Mux Controller

This block chooses what four shared pins carry: 4-wire JTAG signals or general-purpose I/O. It has two ways of entering JTAG mode. The first is a debug session. An external decoder finds the entry sequence on the TEST and reset pins and sends a one-cycle strobe. The session then lasts as long as the TEST pin stays high.

The second way is a software lock bit, set through a one-bit register write port. Once set, the lock holds the pins in 4-wire JTAG mode whatever the TEST pin does. It also turns off the alternative two-wire debug mode.

Only a brown-out reset clears the lock and the session. The block drives a mode select into the pin multiplexer and a disable into the two-wire debug logic.

Top module: `dbg_pin_mux`

## Requirements
- R1: While `borN` is low, and right after it rises, `jtagSel`, `twoWireDis` and `lockRd` are all 0, so the pins act as general-purpose I/O.
- R2: With the lock clear, `jtagSel` goes to 1 only at the clock edge that samples `seqDetected` high. A high TEST level without the strobe does not enter JTAG mode.
- R3: With the lock clear, an active session keeps `jtagSel` at 1 while TEST stays high. TEST passes through a synchroniser of `SYNC_STAGES` flops (default 2). If TEST is low at the edge where it is sampled, `jtagSel` falls to 0 at the `SYNC_STAGES+1`-th edge counting from that edge.
- R4: A write with `regWrEn`=1 and `regWrData`=1 sets the lock at that clock edge. `jtagSel` is then 1 from the next cycle on and stays 1 until a brown-out reset.
- R5: Once the lock is set, a write of `regWrData`=0 leaves it set, and `lockRd` stays 1.
- R6: `twoWireDis` is 1 exactly when the lock is set.
- R7: `lockRd` reads back the current value of the lock bit.
- R8: While the lock is set, TEST going low does not clear `jtagSel`.
- R9: While the lock is clear, a write of 0 leaves it clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| borN | input | 1 | Brown-out reset, active low, asynchronous |
| testPin | input | 1 | Raw TEST pin level |
| seqDetected | input | 1 | One-cycle strobe from the entry-sequence decoder |
| regWrEn | input | 1 | Lock register write enable |
| regWrData | input | 1 | Lock register write value |
| lockRd | output | 1 | Read-back of the lock bit |
| jtagSel | output | 1 | 1 = shared pins carry 4-wire JTAG |
| twoWireDis | output | 1 | 1 = two-wire debug mode disabled |

## Verification
Some properties can be checked on every cycle, and the assertions do so. The lock never falls outside a brown-out. A write of 0 never sets it. A session only starts on the entry strobe. A session ends one edge after the synchronised TEST level is low. The lock always implies JTAG mode.

Other behaviour shows only as results at the ports, and the bench's scenarios cover it. These are the exact latency from a raw TEST fall to the mode change, a session that stays alive while TEST is held, a lock that ignores TEST and zero writes, and a brown-out in the middle of a session or after a lock.

// File: rtl/dbg_pin_mux_pkg.sv
package dbg_pin_mux_pkg;

  // Strobes from control to datapath
  typedef struct packed {
    logic setLock;      // write of 1 to the lock bit
    logic startSession; // entry sequence seen
    logic keepSession;  // synchronised TEST still high
  } muxStrobe_t;

endpackage

// File: rtl/dbg_pin_mux_ctrl.sv
module dbg_pin_mux_ctrl
  import dbg_pin_mux_pkg::*;
(
  input  logic       seqDetected,
  input  logic       regWrEn,
  input  logic       regWrData,
  input  logic       testSync,
  output muxStrobe_t strobe
);

  always_comb begin
    strobe              = '0;
    strobe.setLock      = regWrEn & regWrData;
    strobe.startSession = seqDetected;
    strobe.keepSession  = testSync;
  end

endmodule

// File: rtl/dbg_pin_mux_dp.sv
module dbg_pin_mux_dp
  import dbg_pin_mux_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       borN,
  input  logic       testPin,
  input  muxStrobe_t strobe,
  output logic       testSync,
  output logic       lockQ,
  output logic       sessionQ
);

  localparam int LAST = SYNC_STAGES - 1;

  logic [SYNC_STAGES-1:0] syncQ;

  generate
    if (SYNC_STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge borN)
        if (!borN) syncQ <= '0;
        else       syncQ <= testPin;
    end else begin : g_chain
      always_ff @(posedge clk or negedge borN)
        if (!borN) syncQ <= '0;
        else       syncQ <= {syncQ[SYNC_STAGES-2:0], testPin};
    end
  endgenerate

  assign testSync = syncQ[LAST];

  // Sticky lock: only a brown-out clears it
  always_ff @(posedge clk or negedge borN)
    if (!borN) lockQ <= 1'b0;
    else       lockQ <= lockQ | strobe.setLock;

  // Session lasts while synchronised TEST stays high
  always_ff @(posedge clk or negedge borN)
    if (!borN) sessionQ <= 1'b0;
    else       sessionQ <= strobe.startSession | (sessionQ & strobe.keepSession);

  a_r4_lock_sticky: assert property (@(posedge clk) disable iff (!borN)
    lockQ |=> lockQ);

  a_r9_zero_write: assert property (@(posedge clk) disable iff (!borN)
    (!lockQ && !strobe.setLock) |=> !lockQ);

  a_r2_entry_only: assert property (@(posedge clk) disable iff (!borN)
    (!sessionQ && !strobe.startSession) |=> !sessionQ);

  a_r3_session_end: assert property (@(posedge clk) disable iff (!borN)
    (sessionQ && !testSync && !strobe.startSession) |=> !sessionQ);

endmodule

// File: rtl/dbg_pin_mux.sv
module dbg_pin_mux
  import dbg_pin_mux_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic borN,
  input  logic testPin,
  input  logic seqDetected,
  input  logic regWrEn,
  input  logic regWrData,
  output logic lockRd,
  output logic jtagSel,
  output logic twoWireDis
);

  muxStrobe_t strobe;
  logic       testSync;
  logic       lockQ;
  logic       sessionQ;

  dbg_pin_mux_ctrl i_ctrl (
    .seqDetected (seqDetected),
    .regWrEn     (regWrEn),
    .regWrData   (regWrData),
    .testSync    (testSync),
    .strobe      (strobe)
  );

  dbg_pin_mux_dp #(.SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk      (clk),
    .borN     (borN),
    .testPin  (testPin),
    .strobe   (strobe),
    .testSync (testSync),
    .lockQ    (lockQ),
    .sessionQ (sessionQ)
  );

  assign lockRd     = lockQ;
  assign twoWireDis = lockQ;
  assign jtagSel    = lockQ | sessionQ;

  a_r8_lock_forces_jtag: assert property (@(posedge clk) disable iff (!borN)
    twoWireDis |-> jtagSel);

  a_r5_lock_holds_on_zero: assert property (@(posedge clk) disable iff (!borN)
    (lockRd && regWrEn && !regWrData) |=> lockRd);

endmodule

// File: tb/test_dbg_pin_mux.sv
module test_dbg_pin_mux;

  logic clk = 1'b0;
  logic borN, testPin, seqDetected, regWrEn, regWrData;
  logic lockRd, jtagSel, twoWireDis;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [2:0] exp;   // {jtagSel, twoWireDis, lockRd}
    string      tag;
  } item_t;

  item_t sbq[$];

  always #10 clk = ~clk;  // 50 MHz

  dbg_pin_mux i_dbg_pin_mux (
    .clk(clk), .borN(borN), .testPin(testPin), .seqDetected(seqDetected),
    .regWrEn(regWrEn), .regWrData(regWrData),
    .lockRd(lockRd), .jtagSel(jtagSel), .twoWireDis(twoWireDis)
  );

  // Monitor: compare results away from the active edge
  always @(negedge clk) begin
    while (sbq.size() > 0) begin
      item_t it;
      it = sbq.pop_front();
      checks++;
      if ({jtagSel, twoWireDis, lockRd} !== it.exp) begin
        failures++;
        $display("FAIL %s: actual=%b expected=%b", it.tag,
                 {jtagSel, twoWireDis, lockRd}, it.exp);
      end
    end
  end

  // Driver: apply inputs for one edge, then queue the expected outputs
  task automatic step(input logic tp, input logic seq, input logic we,
                      input logic wd, input logic [2:0] exp, input string tag);
    @(negedge clk);
    testPin = tp; seqDetected = seq; regWrEn = we; regWrData = wd;
    @(posedge clk);
    #1;
    sbq.push_back('{exp, tag});
  endtask

  task automatic bor(input string tag);
    @(negedge clk);
    #2 borN = 1'b0;
    #2 sbq.push_back('{3'b000, tag});
    @(negedge clk);
    #2 borN = 1'b1;
  endtask

  initial begin
    borN = 1'b0; testPin = 1'b0; seqDetected = 1'b0;
    regWrEn = 1'b0; regWrData = 1'b0;
    repeat (2) @(posedge clk);
    #1 sbq.push_back('{3'b000, "R1 reset state"});
    @(negedge clk); borN = 1'b1;

    step(1'b0, 1'b0, 1'b0, 1'b0, 3'b000, "R1 after release");
    for (int i = 0; i < 4; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 3'b000, "R2 TEST high, no strobe");
    step(1'b1, 1'b1, 1'b0, 1'b0, 3'b100, "R2 strobe enters JTAG");
    for (int i = 0; i < 5; i++) step(1'b1, 1'b0, 1'b0, 1'b0, 3'b100, "R3 session held");
    step(1'b0, 1'b0, 1'b0, 1'b0, 3'b100, "R3 TEST low edge1");
    step(1'b0, 1'b0, 1'b0, 1'b0, 3'b100, "R3 TEST low edge2");
    step(1'b0, 1'b0, 1'b0, 1'b0, 3'b000, "R3 TEST low edge3 exits");
    step(1'b0, 1'b0, 1'b1, 1'b0, 3'b000, "R9 zero write unlocked");
    step(1'b0, 1'b0, 1'b0, 1'b0, 3'b000, "R9 stays clear");
    step(1'b0, 1'b0, 1'b1, 1'b1, 3'b111, "R4 R6 R7 lock set");
    step(1'b0, 1'b0, 1'b1, 1'b0, 3'b111, "R5 zero write locked");
    for (int i = 0; i < 6; i++) step(1'b0, 1'b0, 1'b0, 1'b0, 3'b111, "R8 TEST low locked");
    step(1'b1, 1'b1, 1'b0, 1'b0, 3'b111, "R4 strobe while locked");
    bor("R1 brown-out clears lock");
    step(1'b0, 1'b0, 1'b0, 1'b0, 3'b000, "R1 after brown-out");
    step(1'b1, 1'b0, 1'b0, 1'b0, 3'b000, "R2 no strobe");
    step(1'b1, 1'b1, 1'b0, 1'b0, 3'b100, "R2 re-entry");
    step(1'b1, 1'b0, 1'b0, 1'b0, 3'b100, "R3 held again");
    bor("R1 brown-out ends session");
    step(1'b1, 1'b0, 1'b0, 1'b0, 3'b000, "R1 session gone");
    step(1'b1, 1'b0, 1'b1, 1'b1, 3'b111, "R6 R7 lock again");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      failures++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule